// File: doc/BRIEF.md
# Stereo Serial Audio Output Formatter

The block takes two stereo pairs of 24-bit two's-complement samples from a parallel interface and shifts them out, MSB first, on two serial data lines, one line per pair, inside the usual two-channel frame of 32 bit-clock slots per half frame. Either MSB-justified or I2S-style framing can be selected. Both framings run through the same position counter and the same bit selector.

In master role, the system clock `clk` acts as the master clock. It is divided by 4 (master clock = 256 × sample rate) or by 8 (512 × sample rate) to make a bit clock of 64 × sample rate. The frame clock is derived from that bit clock. In slave role the block follows an external bit clock and frame clock, which it synchronises into `clk`. Any frame length from 48 to 128 bit clocks is accepted. A pair written through the parallel port is held pending and is only used from the next frame start. A frame that has already begun is never changed.

Top module: `stereo_ser_fmt`

## Requirements
- R1: In master role, `bck_out` has a period of 4 `clk` cycles when `mclk_x512`=0 and 8 cycles when it is 1. It is low for the first half of each period, counting from reset release.
- R2: In master role, `lrck_out` changes only together with a falling edge of `bck_out`. It toggles every 32 bit-clock periods (50% duty). It is high during the left half when `fmt_i2s`=0 and low during the left half when `fmt_i2s`=1. The left half comes first after reset.
- R3: With `fmt_i2s`=0, slot 0 of a half frame (the slot starting at the frame-clock edge) carries bit 23. Slot s carries bit 23−s for s = 0 to 23.
- R4: With `fmt_i2s`=1, the MSB is delayed by one slot: slot s carries bit 24−s for s = 1 to 24, and slot 0 is low.
- R5: The serial data changes only on a falling edge of the bit clock. Every slot that is not a data slot is driven low.
- R6: `sd_out[n]` carries pair n. The left word of pair n is `smp_left[24n+23:24n]` and the right word is `smp_right[24n+23:24n]`.
- R7: A pair written with `smp_valid` is used from the start of the next left half. A write in the middle of a frame does not change that frame. Zeros are sent until the first load.
- R8: In slave role (`master_en`=0), a falling edge of `bck_in` advances the slot. A change of `lrck_in` starts a half frame at slot 0; its level selects left or right using the R2 polarity. Outputs follow an input edge 3 `clk` cycles later. `bck_out` and `lrck_out` are held low.
- R9: While `rst` is high, `bck_out` and `sd_out` are low and `lrck_out` is at the left-half level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the master clock in master role |
| rst | input | 1 | Synchronous active-high reset |
| master_en | input | 1 | 1: generate clocks; 0: follow external clocks |
| fmt_i2s | input | 1 | 0: MSB-justified; 1: I2S-style |
| mclk_x512 | input | 1 | Master role: 0 = clk is 256×fs, 1 = 512×fs |
| bck_in | input | 1 | External bit clock (slave role) |
| lrck_in | input | 1 | External frame clock (slave role) |
| smp_valid | input | 1 | One-cycle strobe that captures a sample pair set |
| smp_left | input | 48 | Left words, pair n in bits 24n+23:24n |
| smp_right | input | 48 | Right words, pair n in bits 24n+23:24n |
| bck_out | output | 1 | Generated bit clock |
| lrck_out | output | 1 | Generated frame clock |
| sd_out | output | 2 | Serial data, one line per pair |

## Verification
In master role, every output is registered-state driven and moves at the same `clk` edge that wraps the divider. The bench therefore keeps an integer count of edges since reset and predicts the bit clock, frame clock and both data lines from it. It compares them at every falling `clk` edge, so each result is checked in the cycle it is due. In slave role, a bit-clock or frame-clock edge reaches the outputs three `clk` cycles later, after two synchroniser stages and one state register. The bench holds each bit-clock level for five cycles and samples the data lines just before it raises the bit clock. Mid-frame writes are placed so that the unchanged rest of the current frame and the updated next frame are both checked.

// File: rtl/ssf_pkg.sv
package ssf_pkg;

    // width of the in-half slot position (saturates at its maximum)
    localparam int POS_W = 7;
    localparam int POS_MAX = (1 << POS_W) - 1;

    typedef enum logic {
        FMT_MSBJ = 1'b0,
        FMT_I2S  = 1'b1
    } fmt_e;

    // position inside the frame: which half, and slots since its edge
    typedef struct packed {
        logic             right;
        logic [POS_W-1:0] idx;
    } pos_t;

    // frame-clock level that marks the left half
    function automatic logic left_level(fmt_e f);
        return (f == FMT_MSBJ);
    endfunction

endpackage

// File: rtl/ssf_bit_div.sv
module ssf_bit_div #(
    parameter int DIV_LO = 4,
    parameter int DIV_HI = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic sel_hi,
    output logic bck,
    output logic fall_tick
);
    localparam int CW = $clog2(DIV_HI);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;
    logic [CW-1:0] half;

    assign last = sel_hi ? CW'(DIV_HI - 1) : CW'(DIV_LO - 1);
    assign half = sel_hi ? CW'(DIV_HI / 2) : CW'(DIV_LO / 2);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign fall_tick = run && (cnt == last);
    assign bck       = run && (cnt >= half);

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        fall_tick |=> !fall_tick); // R1

endmodule

// File: rtl/ssf_slave_sync.sv
module ssf_slave_sync (
    input  logic clk,
    input  logic rst,
    input  logic bck_in,
    input  logic lrck_in,
    output logic fall_tick,
    output logic frame_tick,
    output logic lrck_lvl
);
    logic [2:0] b_q;
    logic [2:0] l_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            b_q <= '0;
            l_q <= '0;
        end else begin
            b_q <= {b_q[1:0], bck_in};
            l_q <= {l_q[1:0], lrck_in};
        end
    end

    assign fall_tick  = b_q[2] && !b_q[1];
    assign frame_tick = l_q[2] ^ l_q[1];
    assign lrck_lvl   = l_q[1];

endmodule

// File: rtl/ssf_frame_seq.sv
module ssf_frame_seq
    import ssf_pkg::*;
#(
    parameter int SAMPLE_W   = 24,
    parameter int HALF_SLOTS = 32,
    parameter int LANES      = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      master,
    input  fmt_e                      fmt,
    input  logic                      m_fall,
    input  logic                      s_fall,
    input  logic                      s_frame,
    input  logic                      s_lvl,
    input  logic                      smp_valid,
    input  logic [LANES*SAMPLE_W-1:0] smp_left,
    input  logic [LANES*SAMPLE_W-1:0] smp_right,
    output pos_t                      pos,
    output logic [LANES*SAMPLE_W-1:0] act_left,
    output logic [LANES*SAMPLE_W-1:0] act_right
);
    localparam int PW = LANES * SAMPLE_W;

    pos_t          nxt;
    logic          start;
    logic [PW-1:0] pend_left;
    logic [PW-1:0] pend_right;

    always_comb begin
        nxt   = pos;
        start = 1'b0;
        if (master) begin
            if (m_fall) begin
                if (pos.idx >= POS_W'(HALF_SLOTS - 1)) begin
                    nxt.idx   = '0;
                    nxt.right = !pos.right;
                    start     = 1'b1;
                end else begin
                    nxt.idx = pos.idx + 1'b1;
                end
            end
        end else if (s_frame) begin
            nxt.idx   = '0;
            nxt.right = (s_lvl != left_level(fmt));
            start     = 1'b1;
        end else if (s_fall && pos.idx != POS_W'(POS_MAX)) begin
            nxt.idx = pos.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos        <= '0;
            pend_left  <= '0;
            pend_right <= '0;
            act_left   <= '0;
            act_right  <= '0;
        end else begin
            pos <= nxt;
            if (start && !nxt.right) begin
                act_left  <= pend_left;
                act_right <= pend_right;
            end
            if (smp_valid) begin
                pend_left  <= smp_left;
                pend_right <= smp_right;
            end
        end
    end

    AST_LOAD_AT_LEFT: assert property (@(posedge clk) disable iff (rst)
        (!$stable(act_left) || !$stable(act_right)) |-> (pos.idx == '0 && !pos.right)); // R7

    AST_HALF_WRAP: assert property (@(posedge clk) disable iff (rst)
        (master && m_fall && pos.idx == POS_W'(HALF_SLOTS - 1))
        |=> (pos.idx == '0 && pos.right != $past(pos.right))); // R2

endmodule

// File: rtl/ssf_lane.sv
module ssf_lane
    import ssf_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input  fmt_e                fmt,
    input  pos_t                pos,
    input  logic [SAMPLE_W-1:0] left_w,
    input  logic [SAMPLE_W-1:0] right_w,
    output logic                sd
);
    localparam int BW = $clog2(SAMPLE_W);

    logic [SAMPLE_W-1:0] word;
    logic [BW-1:0]       sel;
    int                  rel;

    always_comb begin
        word = pos.right ? right_w : left_w;
        rel  = int'(pos.idx) - ((fmt == FMT_I2S) ? 1 : 0);
        if (rel >= 0 && rel < SAMPLE_W) begin
            sel = BW'(SAMPLE_W - 1 - rel);
            sd  = word[sel];
        end else begin
            sel = '0;
            sd  = 1'b0;
        end
    end

endmodule

// File: rtl/stereo_ser_fmt.sv
module stereo_ser_fmt
    import ssf_pkg::*;
#(
    parameter int SAMPLE_W   = 24,
    parameter int HALF_SLOTS = 32,
    parameter int LANES      = 2,
    parameter int DIV_LO     = 4,
    parameter int DIV_HI     = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      master_en,
    input  logic                      fmt_i2s,
    input  logic                      mclk_x512,
    input  logic                      bck_in,
    input  logic                      lrck_in,
    input  logic                      smp_valid,
    input  logic [LANES*SAMPLE_W-1:0] smp_left,
    input  logic [LANES*SAMPLE_W-1:0] smp_right,
    output logic                      bck_out,
    output logic                      lrck_out,
    output logic [LANES-1:0]          sd_out
);
    localparam int PW = LANES * SAMPLE_W;

    fmt_e          fmt;
    logic          div_bck;
    logic          m_fall;
    logic          s_fall;
    logic          s_frame;
    logic          s_lvl;
    pos_t          pos;
    logic [PW-1:0] act_left;
    logic [PW-1:0] act_right;

    assign fmt = fmt_i2s ? FMT_I2S : FMT_MSBJ;

    ssf_bit_div #(
        .DIV_LO (DIV_LO),
        .DIV_HI (DIV_HI)
    ) u_div (
        .clk       (clk),
        .rst       (rst),
        .run       (master_en),
        .sel_hi    (mclk_x512),
        .bck       (div_bck),
        .fall_tick (m_fall)
    );

    ssf_slave_sync u_sync (
        .clk        (clk),
        .rst        (rst),
        .bck_in     (bck_in),
        .lrck_in    (lrck_in),
        .fall_tick  (s_fall),
        .frame_tick (s_frame),
        .lrck_lvl   (s_lvl)
    );

    ssf_frame_seq #(
        .SAMPLE_W   (SAMPLE_W),
        .HALF_SLOTS (HALF_SLOTS),
        .LANES      (LANES)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .master    (master_en),
        .fmt       (fmt),
        .m_fall    (m_fall),
        .s_fall    (s_fall),
        .s_frame   (s_frame),
        .s_lvl     (s_lvl),
        .smp_valid (smp_valid),
        .smp_left  (smp_left),
        .smp_right (smp_right),
        .pos       (pos),
        .act_left  (act_left),
        .act_right (act_right)
    );

    for (genvar n = 0; n < LANES; n++) begin : g_lane
        ssf_lane #(
            .SAMPLE_W (SAMPLE_W)
        ) u_lane (
            .fmt     (fmt),
            .pos     (pos),
            .left_w  (act_left[n*SAMPLE_W +: SAMPLE_W]),
            .right_w (act_right[n*SAMPLE_W +: SAMPLE_W]),
            .sd      (sd_out[n])
        );
    end

    assign bck_out  = master_en && div_bck;
    assign lrck_out = master_en && (pos.right != left_level(fmt));

    AST_SD_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (master_en && $past(master_en) && $stable(fmt_i2s) && !$fell(bck_out))
        |-> $stable(sd_out)); // R5

    AST_LRCK_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (master_en && $past(master_en) && $stable(fmt_i2s) && !$stable(lrck_out))
        |-> $fell(bck_out)); // R2

    AST_TAIL_LOW: assert property (@(posedge clk) disable iff (rst)
        (int'(pos.idx) >= SAMPLE_W + (fmt_i2s ? 1 : 0)) |-> (sd_out == '0)); // R5

endmodule

// File: tb/test_stereo_ser_fmt.sv
module test_stereo_ser_fmt;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        master_en = 1'b1;
    logic        fmt_i2s = 1'b0;
    logic        mclk_x512 = 1'b0;
    logic        bck_in = 1'b1;
    logic        lrck_in = 1'b0;
    logic        smp_valid = 1'b0;
    logic [47:0] smp_left = '0;
    logic [47:0] smp_right = '0;
    logic        bck_out;
    logic        lrck_out;
    logic [1:0]  sd_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit mchk = 0;

    // reference model state
    int          k = 0;
    logic [47:0] m_pend_l = '0, m_pend_r = '0;
    logic [47:0] m_act_l = '0, m_act_r = '0;

    // 250 MHz: 4 ns period, time unit taken as 1 ns
    always #2 clk = !clk;

    stereo_ser_fmt i_stereo_ser_fmt (
        .clk       (clk),
        .rst       (rst),
        .master_en (master_en),
        .fmt_i2s   (fmt_i2s),
        .mclk_x512 (mclk_x512),
        .bck_in    (bck_in),
        .lrck_in   (lrck_in),
        .smp_valid (smp_valid),
        .smp_left  (smp_left),
        .smp_right (smp_right),
        .bck_out   (bck_out),
        .lrck_out  (lrck_out),
        .sd_out    (sd_out)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_bit(input logic [23:0] w, input int slot, input int dly);
        int rel = slot - dly;
        if (rel >= 0 && rel < 24) return w[23 - rel];
        return 1'b0;
    endfunction

    // behavioural master model: edges since reset
    always @(posedge clk) begin
        int r;
        r = mclk_x512 ? 8 : 4;
        if (rst) begin
            k = 0;
            m_pend_l = '0; m_pend_r = '0;
            m_act_l = '0;  m_act_r = '0;
        end else begin
            k = k + 1;
            if (master_en && (k % r) == 0 && ((k / r) % 64) == 0) begin
                m_act_l = m_pend_l;
                m_act_r = m_pend_r;
            end
            if (smp_valid) begin
                m_pend_l = smp_left;
                m_pend_r = smp_right;
            end
        end
    end

    always @(negedge clk) begin
        if (mchk) begin
            int r, slot, bi;
            bit right, eb, el;
            string tg;
            r     = mclk_x512 ? 8 : 4;
            slot  = (k / r) % 64;
            right = (slot >= 32);
            bi    = slot % 32;
            eb    = ((k % r) >= r / 2);
            el    = fmt_i2s ? right : !right;
            chk(bck_out === eb, "R1 bit clock", bck_out, eb);
            chk(lrck_out === el, "R2 frame clock", lrck_out, el);
            tg = fmt_i2s ? "R4 R5 R6 R7 data" : "R3 R5 R6 R7 data";
            for (int n = 0; n < 2; n++) begin
                logic [23:0] w;
                logic e;
                w = right ? m_act_r[n*24 +: 24] : m_act_l[n*24 +: 24];
                e = exp_bit(w, bi, fmt_i2s ? 1 : 0);
                chk(sd_out[n] === e, tg, sd_out[n], e);
            end
        end
    end

    task automatic write_pair(input logic [47:0] l, input logic [47:0] r);
        smp_left  = l;
        smp_right = r;
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic run_master(input bit f, input bit sel, input logic [47:0] seed);
        int r, frame;
        r = sel ? 8 : 4;
        frame = 64 * r;
        mchk = 0;
        rst = 1'b1;
        master_en = 1'b1;
        fmt_i2s = f;
        mclk_x512 = sel;
        repeat (3) @(negedge clk);
        chk(bck_out === 1'b0, "R9 reset bit clock", bck_out, 0);
        chk(lrck_out === !f, "R9 reset frame clock", lrck_out, !f);
        chk(sd_out === 2'b00, "R9 reset data", sd_out, 0);
        mchk = 1;
        rst = 1'b0;
        repeat (frame / 2) @(negedge clk);
        write_pair(seed, ~seed);
        repeat (frame) @(negedge clk);
        write_pair({seed[23:0], seed[47:24]} ^ 48'h5A5A_C3C3_0F0F, seed + 48'h1234_5678_9ABC);
        repeat (frame + frame / 2 + 10) @(negedge clk);
        mchk = 0;
    endtask

    task automatic run_slave(input bit f, input int n, input logic [47:0] seed);
        localparam int H = 5;
        logic lvl_left;
        logic [47:0] s_l, s_r;
        lvl_left = !f;
        mchk = 0;
        rst = 1'b1;
        master_en = 1'b0;
        fmt_i2s = f;
        bck_in = 1'b1;
        lrck_in = !lvl_left;
        s_l = '0;
        s_r = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        write_pair(seed, seed ^ 48'hFFFF_0000_FFFF);
        repeat (2) @(negedge clk);
        for (int h = 0; h < 6; h++) begin
            bit left;
            left = (h % 2 == 0);
            for (int j = 0; j < n; j++) begin
                bck_in = 1'b0;
                if (j == 0) begin
                    lrck_in = left ? lvl_left : !lvl_left;
                    if (left) begin
                        s_l = m_pend_l;
                        s_r = m_pend_r;
                    end
                end
                if ((h == 0 || h == 2) && j == n / 2) begin
                    smp_left  = seed + 48'(h * 77 + 1);
                    smp_right = ~seed - 48'(h * 3);
                    smp_valid = 1'b1;
                end
                for (int i = 0; i < H; i++) begin
                    @(negedge clk);
                    smp_valid = 1'b0;
                end
                for (int ln = 0; ln < 2; ln++) begin
                    logic [23:0] w;
                    logic e;
                    w = left ? s_l[ln*24 +: 24] : s_r[ln*24 +: 24];
                    e = exp_bit(w, j, f ? 1 : 0);
                    chk(sd_out[ln] === e, f ? "R8 R4 R6 R7 slave data" : "R8 R3 R6 R7 slave data",
                        sd_out[ln], e);
                end
                if (j == 0) begin
                    chk({bck_out, lrck_out} === 2'b00, "R8 clocks held low", {bck_out, lrck_out}, 0);
                end
                bck_in = 1'b1;
                repeat (H) @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        run_master(1'b0, 1'b0, 48'hA5C3F1_3C5A0F);
        run_master(1'b1, 1'b0, 48'h800001_7FFFFE);
        run_master(1'b0, 1'b1, 48'h123456_FEDCBA);
        run_master(1'b1, 1'b1, 48'hC0FFEE_0BADF0);
        run_slave(1'b0, 24, 48'h9A3B5C_6D7E8F);
        run_slave(1'b1, 24, 48'hF0E1D2_C3B4A5);
        run_slave(1'b0, 32, 48'h13579B_2468AC);
        run_slave(1'b1, 32, 48'hDEADBE_EF0123);
        run_slave(1'b0, 64, 48'h0F1E2D_3C4B5A);
        run_slave(1'b1, 64, 48'h7766AA_5511CC);
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule